// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block is the 8-bit control/status register of one DMA channel. A CPU register bus writes it with a byte value and a per-bit mask, so a full-byte write and a single-bit write use the same path. It reads the register through a combinational read port. The block holds the channel enable. It turns software writes of two write-only strobe bits into one-cycle start and initialize pulses for the channel's transfer engine, and it keeps a sticky completion flag that the engine sets and that any read clears.

The engine reports each transfer with a strobe and marks the final transfer of a block with a last flag. When both are high in one cycle, the enable is cleared at once and the completion flag is raised one cycle later. A read in the cycle between the two updates shows enable and completion both at 0. The start strobe is accepted only while the channel is enabled and no completion is pending. The initialize strobe is accepted only while the channel is disabled, and it also clears the completion flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, rd_data is 0x00 and ch_enable, ch_start and ch_init are 0.
- R2: rd_data bit 0 is the enable, bit 7 is the completion flag, and bits 1 to 6 always read 0, including after 1s are written to them.
- R3: A write updates the enable (bit 0) only when wr_mask bit 0 is 1, taking wr_data bit 0 at the next edge. A zero mask leaves the register unchanged, and clearing the enable aborts the channel.
- R4: A cycle with eng_xfer and eng_last both 1 clears the enable at the next edge. eng_last without eng_xfer, or eng_xfer without eng_last, has no effect.
- R5: The completion flag rises one cycle after the enable clears, so the read in between returns 0x00.
- R6: A cycle with rd_en at 1 clears the completion flag at the next edge. If the flag is being set at that same edge, it stays at 1.
- R7: A write of 1 to bit 2 (masked in) pulses ch_start for one cycle, starting the next cycle, only if the enable was 1 and the flag was 0 before the write. Otherwise it is ignored. An enable written in the same byte does not qualify it.
- R8: A write of 1 to bit 1 (masked in) pulses ch_init for one cycle, starting the next cycle, only if the enable was 0 before the write. Otherwise it is ignored.
- R9: An accepted initialize also clears the completion flag at the same edge that raises ch_init.
- R10: A terminal-count cycle wins over a software write that sets the enable in the same cycle: the enable ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write select |
| rd_en | input | 1 | Register read strobe; clears the completion flag |
| rd_data | output | 8 | Register read value |
| eng_xfer | input | 1 | Engine: one transfer done this cycle |
| eng_last | input | 1 | Engine: this transfer is the block's last |
| ch_enable | output | 1 | Channel enable to the engine |
| ch_start | output | 1 | One-cycle software start pulse |
| ch_init | output | 1 | One-cycle channel initialize pulse |

## Verification
Enable changes, start and initialize pulses, and read-clears are all due on the first edge after the stimulus cycle. The completion flag is due on the second edge. The driver applies each stimulus for exactly one cycle and queues the expected register value and pulse levels for the following cycle. The monitor compares them at the falling edge of that cycle, and plain idle steps cover the second-edge flag and the return of pulses to 0.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int W       = 8,
  parameter int EN_B    = 0,
  parameter int INIT_B  = 1,
  parameter int START_B = 2,
  parameter int TC_B    = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_mask,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         eng_xfer,
  input  logic         eng_last,
  output logic         ch_enable,
  output logic         ch_start,
  output logic         ch_init
);

  logic en_q, tc_q, pend_q, start_q, init_q;

  wire tc_evt    = eng_xfer & eng_last;
  wire en_wr     = wr_en & wr_mask[EN_B];
  wire start_req = wr_en & wr_mask[START_B] & wr_data[START_B] & en_q & ~tc_q;
  wire init_req  = wr_en & wr_mask[INIT_B] & wr_data[INIT_B] & ~en_q;

  wire unused_bits = ^{wr_data, wr_mask};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      tc_q    <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      if (tc_evt)      en_q <= 1'b0;
      else if (en_wr)  en_q <= wr_data[EN_B];
      pend_q  <= tc_evt;
      tc_q    <= pend_q | (tc_q & ~rd_en & ~init_req);
      start_q <= start_req;
      init_q  <= init_req;
    end
  end

  always_comb begin
    rd_data       = '0;
    rd_data[EN_B] = en_q;
    rd_data[TC_B] = tc_q;
  end

  assign ch_enable = en_q;
  assign ch_start  = start_q;
  assign ch_init   = init_q;

  p_tc_clears_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_xfer && eng_last) |-> !ch_enable);

  p_flag_after_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> !$past(en_q));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && !$past(pend_q)) |-> !rd_data[TC_B]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_q) |-> rd_data[TC_B]);

  p_start_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> ($past(en_q) && !$past(tc_q)));

  p_init_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_init |-> !$past(en_q));

  p_init_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_init && !$past(pend_q)) |-> !rd_data[TC_B]);

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_start && ch_init));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[TC_B-1:EN_B+1] == '0);

endmodule

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] wr_mask = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       eng_xfer = 1'b0;
  logic       eng_last = 1'b0;
  logic       ch_enable, ch_start, ch_init;

  dma_chan_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_en(rd_en), .rd_data(rd_data), .eng_xfer(eng_xfer), .eng_last(eng_last),
    .ch_enable(ch_enable), .ch_start(ch_start), .ch_init(ch_init)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [7:0] rd;
    logic       st;
    logic       in;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd_data !== it.rd || ch_enable !== it.rd[0] ||
          ch_start !== it.st || ch_init !== it.in) begin
        errors++;
        $display("FAIL %s: rd=%h en=%b st=%b in=%b expected rd=%h en=%b st=%b in=%b",
                 it.req, rd_data, ch_enable, ch_start, ch_init, it.rd, it.rd[0], it.st, it.in);
      end
    end
  end

  task automatic step(input logic w, input logic [7:0] m, input logic [7:0] d,
                      input logic r, input logic x, input logic l,
                      input logic [7:0] erd, input logic est, input logic ein,
                      input string req);
    item_t it;
    @(negedge clk);
    #1;
    wr_en = w; wr_mask = m; wr_data = d; rd_en = r; eng_xfer = x; eng_last = l;
    it.cyc = cyc + 1; it.rd = erd; it.st = est; it.in = ein; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input logic [7:0] erd, input string req);
    step(0, 8'h00, 8'h00, 0, 0, 0, erd, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(8'h00, "R1 reset state");
    step(1, 8'h01, 8'h01, 0, 0, 0, 8'h01, 0, 0, "R3 set enable");
    step(1, 8'h78, 8'hFF, 0, 0, 0, 8'h01, 0, 0, "R2 reserved bits read 0");
    step(1, 8'h00, 8'h00, 0, 0, 0, 8'h01, 0, 0, "R3 zero mask no change");
    step(1, 8'h04, 8'h04, 0, 0, 0, 8'h01, 1, 0, "R7 start accepted");
    idle(8'h01, "R7 start one cycle");
    step(1, 8'h02, 8'h02, 0, 0, 0, 8'h01, 0, 0, "R8 init ignored when enabled");
    step(0, 8'h00, 8'h00, 0, 0, 1, 8'h01, 0, 0, "R4 last without xfer");
    step(0, 8'h00, 8'h00, 0, 1, 0, 8'h01, 0, 0, "R4 xfer without last");
    step(0, 8'h00, 8'h00, 0, 1, 1, 8'h00, 0, 0, "R4 R5 enable cleared, flag not yet");
    idle(8'h80, "R5 flag set second cycle");
    step(1, 8'h04, 8'h04, 0, 0, 0, 8'h80, 0, 0, "R7 start ignored when disabled");
    step(1, 8'h01, 8'h01, 0, 0, 0, 8'h81, 0, 0, "R3 resume enable");
    step(1, 8'h04, 8'h04, 0, 0, 0, 8'h81, 0, 0, "R7 start ignored with flag set");
    step(0, 8'h00, 8'h00, 1, 0, 0, 8'h01, 0, 0, "R6 read clears flag");
    step(0, 8'h00, 8'h00, 1, 0, 0, 8'h01, 0, 0, "R6 read with flag clear");
    step(1, 8'h01, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R3 abort");
    step(1, 8'h05, 8'h05, 0, 0, 0, 8'h01, 0, 0, "R7 enable and start same byte");
    step(0, 8'h00, 8'h00, 0, 1, 1, 8'h00, 0, 0, "R5 intermediate");
    step(0, 8'h00, 8'h00, 1, 0, 0, 8'h80, 0, 0, "R6 set wins over read");
    idle(8'h80, "R6 flag held");
    step(1, 8'h02, 8'h02, 0, 0, 0, 8'h00, 0, 1, "R8 R9 init pulse clears flag");
    idle(8'h00, "R8 init one cycle");
    step(1, 8'h01, 8'h01, 0, 0, 0, 8'h01, 0, 0, "R3 enable again");
    step(1, 8'h01, 8'h01, 0, 1, 1, 8'h00, 0, 0, "R10 terminal count beats write");
    idle(8'h80, "R10 flag follows");
    step(0, 8'h00, 8'h00, 1, 0, 0, 8'h00, 0, 0, "R6 final read clear");
    idle(8'h00, "R1 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
    end
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule